// File: doc/BRIEF.md
# Asynchronous Memory Access Sequencer with External Wait

This block turns single-word requests into read or write cycles on an asynchronous external memory behind one chip select. Every cycle passes through up to three timed phases: an address setup phase, a strobe pulse phase and a hold phase. The read strobe or the write strobe is driven low only during the pulse. A 6-bit count per phase comes from static configuration inputs. A setup or hold count of zero skips that phase. The pulse always lasts at least one cycle.

The external device can stretch an access through an active-low wait pin. The pin passes through a synchronizer chain before it is used, and it only matters while a strobe is in its pulse phase. A 2-bit mode input selects how the wait pin acts. It can be ignored, it can freeze the whole sequencer, or it can only hold back the end of the pulse. After every read, a programmable number of data-float cycles must pass before the next access may start, so that the memory has released the data bus.

Requests use a valid/ready handshake. A one-cycle done pulse returns, and it carries the captured read data for reads.

Top module: `ext_mem_seq`

## Requirements
- R1: While reset is held and after it ends with no request, both strobes are high (inactive), the data output enable is low, `req_ready` is high and `rsp_done` is low.
- R2: An accepted access has exactly S setup cycles with both strobes high, then max(P,1) pulse cycles, then H hold cycles. Here S, P and H are `cfg_setup`, `cfg_pulse` and `cfg_hold`. Setup starts in the cycle after acceptance. `rsp_done` is high for one cycle, in the cycle after the last hold cycle (or after the last pulse cycle when H is 0).
- R3: In a write, `mem_wr_n` is low only in the pulse, `mem_rd_n` stays high, and `mem_oe` is high from the first setup cycle through the last hold cycle. `mem_dout` and `mem_addr` carry the request's data and address during that span. The two strobes are never low together.
- R4: In a read, `mem_rd_n` is low only in the pulse and `mem_oe` stays low. `rsp_rdata` shows the `mem_din` value sampled in the last pulse cycle while `rsp_done` is high.
- R5: With `cfg_wait_mode` equal to 00 or 01, the wait pin has no effect on any phase length.
- R6: The wait pin passes through two flip-flops. A low level first seen at the pin in cycle k acts in cycle k+2. A release first seen in cycle j stops acting from cycle j+2.
- R7: With mode 10 (frozen), every cycle of the pulse in which the synchronized wait is low adds one cycle to the pulse. The strobes, address and data stay unchanged. A pulse of P cycles with wait low at the pin for W cycles from its first cycle lasts P+W cycles when P is at least 3.
- R8: With mode 11 (ready), the pulse counter keeps counting, but the last pulse cycle repeats while the synchronized wait is low. With the same stimulus as in R7 and P at least 3, the pulse lasts W+3 cycles if P ≤ W+2, and P cycles otherwise.
- R9: A wait assertion that acts only during setup, hold or idle cycles changes no phase length.
- R10: After a read whose last pulse cycle is L, no access is accepted before cycle L+1+F, where F is `cfg_float`. With a hold of H cycles this adds max(0,F−H) idle cycles in front of the next access. Writes add no such delay.
- R11: `cfg_err` is high exactly when the mode enables wait (bit 1 set) and `cfg_hold` is zero.
- R12: `req_ready` is high only when the sequencer is idle and no data-float cycles remain. `rsp_done` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | CNT_W | Setup phase length in cycles |
| cfg_pulse | input | CNT_W | Pulse phase length (0 treated as 1) |
| cfg_hold | input | CNT_W | Hold phase length in cycles |
| cfg_float | input | CNT_W | Data-float cycles counted from the end of a read pulse |
| cfg_wait_mode | input | 2 | 00/01 ignore wait, 10 frozen, 11 ready |
| cfg_err | output | 1 | Wait enabled with a zero hold count |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data driven to the memory |
| mem_oe | output | 1 | Data bus output enable |
| mem_din | input | DATA_W | Data from the memory |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_wait_n | input | 1 | External wait, active low |

## Verification
The wait stall and the end of the pulse can land on the same cycle. In ready mode, the synchronized wait can act in exactly the cycle where the pulse counter reaches its last count. In frozen mode, it can act in the last pulse cycle itself. The bench provokes this by driving the wait pin low at the first pulse cycle for 1 or 3 cycles, across pulse lengths of 1 to 5. The synchronized wait then arrives before, on, or after the final pulse cycle. Each measured pulse length is compared with the closed-form lengths in R7 and R8. A second collision is the end of a read, which starts the float count, against the next request. There the bench computes the earliest legal accept cycle from the recorded last pulse cycle.

// File: rtl/ems_pkg.sv
package ems_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_PULSE = 2'd2,
      PH_HOLD  = 2'd3
   } ems_phase_e;

   localparam logic [1:0] WM_FROZEN = 2'b10;
   localparam logic [1:0] WM_READY  = 2'b11;

endpackage

// File: rtl/ems_wait_sync.sv
module ems_wait_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic sync_n
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         initial $fatal(1, "ems_wait_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], pin_n};
   end

   assign sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ems_turnaround.sv
module ems_turnaround #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy
);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  left_q <= '0;
      else if (load)               left_q <= load_val;
      else if (left_q != '0)       left_q <= left_q - CNT_W'(1);
   end

   assign busy = (left_q != '0);

endmodule

// File: rtl/ems_phase_fsm.sv
module ems_phase_fsm
   import ems_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len_setup,
   input  logic [CNT_W-1:0] len_pulse,
   input  logic [CNT_W-1:0] len_hold,
   input  logic [1:0]       wait_mode,
   input  logic             wait_act,
   output ems_phase_e       phase,
   output logic             pulse_end,
   output logic             access_end
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   ems_phase_e       phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] pulse_eff;
   logic             freeze, last_stall, cnt_last;

   assign pulse_eff  = (len_pulse == '0) ? ONE : len_pulse;
   assign cnt_last   = (cnt_q == ONE);
   assign freeze     = (phase_q == PH_PULSE) && (wait_mode == WM_FROZEN) && wait_act;
   assign last_stall = (phase_q == PH_PULSE) && (wait_mode == WM_READY) && wait_act && cnt_last;
   assign pulse_end  = (phase_q == PH_PULSE) && cnt_last && !freeze && !last_stall;
   assign access_end = (pulse_end && (len_hold == '0)) || ((phase_q == PH_HOLD) && cnt_last);

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               if (len_setup != '0) begin
                  phase_d = PH_SETUP;
                  cnt_d   = len_setup;
               end else begin
                  phase_d = PH_PULSE;
                  cnt_d   = pulse_eff;
               end
            end
         end
         PH_SETUP: begin
            if (cnt_last) begin
               phase_d = PH_PULSE;
               cnt_d   = pulse_eff;
            end else begin
               cnt_d = cnt_q - ONE;
            end
         end
         PH_PULSE: begin
            if (freeze || last_stall) begin
               cnt_d = cnt_q;
            end else if (!cnt_last) begin
               cnt_d = cnt_q - ONE;
            end else if (len_hold != '0) begin
               phase_d = PH_HOLD;
               cnt_d   = len_hold;
            end else begin
               phase_d = PH_IDLE;
               cnt_d   = '0;
            end
         end
         PH_HOLD: begin
            if (cnt_last) begin
               phase_d = PH_IDLE;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q - ONE;
            end
         end
         default: begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   assign phase = phase_q;

endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
   import ems_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_setup,
   input  logic [CNT_W-1:0]  cfg_pulse,
   input  logic [CNT_W-1:0]  cfg_hold,
   input  logic [CNT_W-1:0]  cfg_float,
   input  logic [1:0]        cfg_wait_mode,
   output logic              cfg_err,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_oe,
   input  logic [DATA_W-1:0] mem_din,
   output logic              mem_rd_n,
   output logic              mem_wr_n,
   input  logic              mem_wait_n
);

   generate
      if (CNT_W < 2 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         initial $fatal(1, "ext_mem_seq: illegal width parameter");
      end
   endgenerate

   ems_phase_e        phase;
   logic              pulse_end, access_end, float_busy;
   logic              wait_n_sync, wait_act, accept;
   logic              wr_q, done_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;

   ems_wait_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (mem_wait_n),
      .sync_n (wait_n_sync)
   );

   assign wait_act = cfg_wait_mode[1] && !wait_n_sync;

   assign req_ready = (phase == PH_IDLE) && !float_busy;
   assign accept    = req_valid && req_ready;

   ems_phase_fsm #(.CNT_W(CNT_W)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .len_setup  (cfg_setup),
      .len_pulse  (cfg_pulse),
      .len_hold   (cfg_hold),
      .wait_mode  (cfg_wait_mode),
      .wait_act   (wait_act),
      .phase      (phase),
      .pulse_end  (pulse_end),
      .access_end (access_end)
   );

   ems_turnaround #(.CNT_W(CNT_W)) i_float (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pulse_end && !wr_q),
      .load_val (cfg_float),
      .busy     (float_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         wr_q    <= req_write;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         if (pulse_end && !wr_q) rdata_q <= mem_din;
         done_q <= access_end;
      end
   end

   assign mem_rd_n  = !((phase == PH_PULSE) && !wr_q);
   assign mem_wr_n  = !((phase == PH_PULSE) && wr_q);
   assign mem_oe    = wr_q && (phase != PH_IDLE);
   assign mem_addr  = addr_q;
   assign mem_dout  = wdata_q;
   assign rsp_done  = done_q;
   assign rsp_rdata = rdata_q;
   assign cfg_err   = cfg_wait_mode[1] && (cfg_hold == '0);

endmodule

// File: rtl/ems_checker.sv
module ems_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] wait_mode,
   input logic       wait_act,
   input logic       rd_n,
   input logic       wr_n,
   input logic       oe,
   input logic       req_ready,
   input logic       rsp_done
);

   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   assert_write_drives_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> oe);

   assert_read_bus_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !oe);

   assert_frozen_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_mode == 2'b10 && wait_act && !(rd_n && wr_n)) |=> ($stable(rd_n) && $stable(wr_n)));

   assert_ready_holds_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_mode == 2'b11 && wait_act && !(rd_n && wr_n)) |=> !(rd_n && wr_n));

   assert_ready_only_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (rd_n && wr_n && !oe));

   assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

endmodule

bind ext_mem_seq ems_checker i_ems_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .wait_mode (cfg_wait_mode),
   .wait_act  (wait_act),
   .rd_n      (mem_rd_n),
   .wr_n      (mem_wr_n),
   .oe        (mem_oe),
   .req_ready (req_ready),
   .rsp_done  (rsp_done)
);

// File: tb/test_ext_mem_seq.sv
module test_ext_mem_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cfg_setup = '0, cfg_pulse = 6'd1, cfg_hold = '0, cfg_float = '0;
   logic [1:0]  cfg_wait_mode = 2'b00;
   logic        cfg_err;
   logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic        rsp_done;
   logic [15:0] rsp_rdata, mem_addr, mem_dout, mem_din;
   logic        mem_oe, mem_rd_n, mem_wr_n;
   logic        mem_wait_n = 1'b1;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit wait_busy = 1'b0, finished = 1'b0;
   bit prev_rd = 1'b0;
   int prev_last = 0, prev_float = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign mem_din = mem_addr ^ 16'hA5C3;

   ext_mem_seq i_ext_mem_seq (
      .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
      .cfg_hold(cfg_hold), .cfg_float(cfg_float), .cfg_wait_mode(cfg_wait_mode),
      .cfg_err(cfg_err), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_dout(mem_dout), .mem_oe(mem_oe), .mem_din(mem_din),
      .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_wait_n(mem_wait_n)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive_wait(input int n);
      wait_busy  = 1'b1;
      mem_wait_n = 1'b0;
      repeat (n) @(negedge clk);
      mem_wait_n = 1'b1;
      wait_busy  = 1'b0;
   endtask

   function automatic int pulse_len(input int p, input int w, input logic [1:0] m);
      int pe = (p == 0) ? 1 : p;
      if (w == 0 || m[1] == 1'b0 || pe < 3) return pe;
      if (m == 2'b10) return pe + w;
      return (pe <= w + 2) ? w + 3 : pe;
   endfunction

   // One access; starts and ends at a negedge.
   task automatic run_access(input bit wr, input logic [15:0] addr, input logic [15:0] data,
                             input int w, input int pre_w,
                             input int e_setup, input int e_pulse, input int e_hold,
                             input string rq);
      int t0, acc, exp_acc, s, p, h, last;
      while (wait_busy) @(negedge clk);
      repeat (2) @(negedge clk);
      req_write = wr; req_addr = addr; req_wdata = data; req_valid = 1'b1;
      t0 = cyc;
      while (!req_ready) @(negedge clk);
      acc = cyc;
      exp_acc = t0;
      if (prev_rd && (prev_last + 1 + prev_float > t0)) exp_acc = prev_last + 1 + prev_float;
      check(acc == exp_acc, "R10", "accept cycle", acc, exp_acc);
      @(negedge clk);
      req_valid = 1'b0;
      if (pre_w > 0) fork drive_wait(pre_w); join_none
      s = 0;
      while (mem_rd_n && mem_wr_n && s < 200) begin
         if (wr && !mem_oe) check(1'b0, "R3", "oe in setup", 0, 1);
         s++;
         @(negedge clk);
      end
      check(s == e_setup, {"R2 ", rq}, "setup cycles", s, e_setup);
      if (w > 0) fork drive_wait(w); join_none
      p = 0; last = cyc;
      while (!(mem_rd_n && mem_wr_n) && p < 200) begin
         if (p == 0) begin
            if (wr) check(!mem_wr_n && mem_rd_n && mem_oe && mem_dout == data && mem_addr == addr,
                          "R3", "write strobe/bus", {mem_wr_n, mem_rd_n, mem_oe}, 3'b011);
            else    check(!mem_rd_n && mem_wr_n && !mem_oe && mem_addr == addr,
                          "R4", "read strobe/bus", {mem_rd_n, mem_wr_n, mem_oe}, 3'b010);
         end
         p++; last = cyc;
         @(negedge clk);
      end
      check(p == e_pulse, rq, "pulse cycles", p, e_pulse);
      h = 0;
      while (!rsp_done && h < 200) begin
         if (mem_oe != wr) check(1'b0, "R3", "oe in hold", mem_oe, wr);
         h++;
         @(negedge clk);
      end
      check(h == e_hold, "R2", "hold cycles", h, e_hold);
      if (!wr) check(rsp_rdata == (addr ^ 16'hA5C3), "R4", "read data", rsp_rdata, addr ^ 16'hA5C3);
      @(negedge clk);
      check(!rsp_done, "R12", "done width", rsp_done, 0);
      prev_rd = !wr; prev_last = last; prev_float = cfg_float;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int iter = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(mem_rd_n && mem_wr_n && !mem_oe && req_ready && !rsp_done, "R1", "reset outputs",
            {mem_rd_n, mem_wr_n, mem_oe, req_ready, rsp_done}, 5'b11010);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_rd_n && mem_wr_n && !mem_oe && req_ready && !rsp_done, "R1", "idle outputs",
            {mem_rd_n, mem_wr_n, mem_oe, req_ready, rsp_done}, 5'b11010);

      // R11 configuration error flag
      cfg_wait_mode = 2'b10; cfg_hold = 6'd0; #1;
      check(cfg_err == 1'b1, "R11", "frozen hold 0", cfg_err, 1);
      cfg_wait_mode = 2'b11; cfg_hold = 6'd2; #1;
      check(cfg_err == 1'b0, "R11", "ready hold 2", cfg_err, 0);
      cfg_wait_mode = 2'b00; cfg_hold = 6'd0; #1;
      check(cfg_err == 1'b0, "R11", "off hold 0", cfg_err, 0);
      @(negedge clk);

      // R9: wait acting only during setup changes nothing (frozen and ready)
      for (int m = 2; m < 4; m++) begin
         cfg_wait_mode = 2'(m); cfg_setup = 6'd6; cfg_pulse = 6'd3; cfg_hold = 6'd1; cfg_float = 6'd0;
         run_access(1'b1, 16'h1234, 16'hBEEF, 0, 2, 6, 3, 1, "R9");
         run_access(1'b0, 16'h4321, 16'h0000, 0, 2, 6, 3, 1, "R9");
      end

      // Sweep: mode x pulse x setup x hold x wait length (R2 R5 R6 R7 R8 R10)
      for (int m = 0; m < 4; m++)
         for (int p = 0; p < 6; p++)
            for (int si = 0; si < 2; si++)
               for (int hi = 0; hi < 3; hi++)
                  for (int wi = 0; wi < 3; wi++) begin
                     int hv = (hi == 2) ? 3 : hi;
                     int wv = (wi == 2) ? 3 : wi;
                     int ep;
                     string rq;
                     cfg_wait_mode = 2'(m);
                     cfg_pulse = 6'(p); cfg_setup = 6'(si * 2); cfg_hold = 6'(hv);
                     cfg_float = 6'((iter % 3) * 3);
                     ep = pulse_len(p, wv, 2'(m));
                     rq = (m < 2) ? "R5" : ((m == 2) ? "R7 R6" : "R8 R6");
                     run_access(1'b1, 16'(iter * 37 + 5), 16'(iter * 91) ^ 16'h3C3C,
                                wv, 0, si * 2, ep, hv, rq);
                     run_access(1'b0, 16'(iter * 53 + 9), 16'h0000,
                                wv, 0, si * 2, ep, hv, rq);
                     iter++;
                  end

      // R10: read then write directly with float 5, hold 1
      cfg_wait_mode = 2'b00; cfg_setup = 6'd1; cfg_pulse = 6'd2; cfg_hold = 6'd1; cfg_float = 6'd5;
      run_access(1'b0, 16'h0F0F, 16'h0000, 0, 0, 1, 2, 1, "R10");
      run_access(1'b1, 16'hF0F0, 16'h5555, 0, 0, 1, 2, 1, "R10");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule